// File: doc/BRIEF.md
# Nested Vector-Block Loop Sequencer

This block produces the loop indices for a vector instruction context made of four nested hardware loops. The outermost loop is the program counter. Inside it is a 5-bit in-block instruction index, then a vector element index bounded by a vector length, and innermost a sub-element index bounded by a sub-vector length. A start pulse enters vector-block mode and carries the block base address, the number of instructions, the block length in bytes and the two loop bounds. While the mode is active the program counter output stays fixed at the block base. Each step pulse advances only the innermost active loop, and a carry passes outward when that loop wraps.

When the last sub-element of the last element of the last instruction is stepped, the block exits. The busy flag falls, every index returns to zero and the program counter moves past the block by the given byte length. A branch or jump attempt inside the block is illegal. It raises a flag for one cycle and freezes every counter for that cycle.

Top module: `vblk_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `busy_o`, `illegal_o`, `pc_o` and all three index outputs to zero.
- R2: A `start_i` pulse while idle sets `busy_o` on the next edge, loads `pc_o` with `base_pc_i`, zeroes all indices and captures count, length and both bounds.
- R3: While `busy_o` is high and the block has not completed, `pc_o` does not change.
- R4: Each accepted step raises `sub_idx_o` by one. When it equals SUBVL-1 it wraps to 0 and carries into the element index. A `subvl_i` of 0 acts as 1.
- R5: The element index raises by one only on a sub-element carry. At VL-1 it wraps to 0 and carries into the in-block index.
- R6: With a nonzero VL the in-block index advances only when the element and sub-element loops both complete, so every iteration of one instruction finishes before the next instruction begins.
- R7: If `branch_i` is high while busy, `illegal_o` is high in the following cycle and no index or PC changes, even if `step_i` is also high. When idle, `branch_i` raises no flag.
- R8: A carry out of the in-block index at count-1 clears `busy_o` and all indices, and sets `pc_o` to base plus `block_len_i`. An instruction count of 0 acts as 1.
- R9: When VL is 0 each step advances the in-block index directly, and the element and sub-element indices stay 0.
- R10: A `start_i` pulse while busy is ignored: PC, indices and captured bounds keep their values.
- R11: A step while idle changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Enter vector-block mode |
| base_pc_i | input | PC_W | Block start address |
| instr_cnt_i | input | BLK_W | Instructions in the block (0 acts as 1) |
| block_len_i | input | PC_W | Block length in bytes |
| vl_i | input | VL_W | Element count per instruction |
| subvl_i | input | SUB_W | Sub-elements per element (0 acts as 1) |
| step_i | input | 1 | Advance innermost active loop |
| branch_i | input | 1 | Branch or jump attempted |
| pc_o | output | PC_W | Program counter, frozen while busy |
| blk_idx_o | output | BLK_W | In-block instruction index |
| elem_idx_o | output | VL_W | Element index |
| sub_idx_o | output | SUB_W | Sub-element index |
| busy_o | output | 1 | Vector-block mode active |
| illegal_o | output | 1 | Branch attempted inside the block (previous cycle) |

## Verification
The bench checks every step of a full 2x3x2 walk. A design that carried into the wrong loop, or advanced the instruction index early, would break the expected order at the first element boundary. Zero VL, zero SUBVL and zero instruction count are each run on their own. Designs that treated zero as "many" would stay busy, and designs that did not skip the element loop would move the element index. A branch given together with a step must leave every index in place. A start pulse during a block must not reload the base. A design with an off-by-one exit would put the wrong PC on the output or leave busy high.

// File: rtl/vblk_pkg.sv
`timescale 1ns/1ps
package vblk_pkg;

  typedef enum logic {VB_IDLE = 1'b0, VB_ACTIVE = 1'b1} vb_state_e;

  // last legal index of a loop of n passes; a count of zero acts as one pass
  function automatic int unsigned last_index(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // address after the block
  function automatic logic [63:0] exit_pc(input logic [63:0] base, input logic [63:0] len);
    return base + len;
  endfunction

endpackage

// File: rtl/vblk_wrap_cnt.sv
`timescale 1ns/1ps
module vblk_wrap_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] idx_o,
  output logic         at_last_o
);

  logic [W-1:0] idx_q;

  assign at_last_o = (idx_q == last_i);
  assign idx_o     = idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  idx_q <= '0;
    else if (adv_i)    idx_q <= at_last_o ? '0 : idx_q + W'(1);
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (adv_i && at_last_o && !clr_i) |=> (idx_o == '0)); // R4
  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !clr_i) |=> $stable(idx_o)); // R5

endmodule

// File: rtl/vblk_ctrl.sv
`timescale 1ns/1ps
module vblk_ctrl
  import vblk_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int BLK_W = 5,
  parameter int VL_W  = 6,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PC_W-1:0]  base_pc_i,
  input  logic [BLK_W-1:0] instr_cnt_i,
  input  logic [PC_W-1:0]  block_len_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [SUB_W-1:0] subvl_i,
  input  logic             step_i,
  input  logic             branch_i,
  input  logic             sub_at_last_i,
  input  logic             elem_at_last_i,
  input  logic             blk_at_last_i,
  output logic             clr_o,
  output logic             sub_adv_o,
  output logic             elem_adv_o,
  output logic             blk_adv_o,
  output logic             done_o,
  output logic             vl_zero_o,
  output logic [SUB_W-1:0] sub_last_o,
  output logic [VL_W-1:0]  elem_last_o,
  output logic [BLK_W-1:0] blk_last_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             busy_o,
  output logic             illegal_o
);

  vb_state_e        state_q;
  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  cfg_len_q;
  logic [BLK_W-1:0] cfg_cnt_q;
  logic [VL_W-1:0]  cfg_vl_q;
  logic [SUB_W-1:0] cfg_sub_q;
  logic             illegal_q;

  logic active;
  logic start_ok;
  logic adv;

  assign active    = (state_q == VB_ACTIVE);
  assign start_ok  = start_i && !active;
  assign adv       = active && step_i && !branch_i;
  assign vl_zero_o = (cfg_vl_q == '0);

  assign sub_last_o  = SUB_W'(last_index(32'(cfg_sub_q)));
  assign elem_last_o = VL_W'(last_index(32'(cfg_vl_q)));
  assign blk_last_o  = BLK_W'(last_index(32'(cfg_cnt_q)));

  // carry chain: sub -> element -> in-block index -> exit
  assign sub_adv_o  = adv && !vl_zero_o;
  assign elem_adv_o = sub_adv_o && sub_at_last_i;
  assign blk_adv_o  = adv && (vl_zero_o || (sub_at_last_i && elem_at_last_i));
  assign done_o     = blk_adv_o && blk_at_last_i;
  assign clr_o      = start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= VB_IDLE;
      pc_q      <= '0;
      cfg_len_q <= '0;
      cfg_cnt_q <= '0;
      cfg_vl_q  <= '0;
      cfg_sub_q <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= active && branch_i;
      if (start_ok) begin
        state_q   <= VB_ACTIVE;
        pc_q      <= base_pc_i;
        cfg_len_q <= block_len_i;
        cfg_cnt_q <= instr_cnt_i;
        cfg_vl_q  <= vl_i;
        cfg_sub_q <= subvl_i;
      end else if (done_o) begin
        state_q <= VB_IDLE;
        pc_q    <= PC_W'(exit_pc(64'(pc_q), 64'(cfg_len_q)));
      end
    end
  end

  assign pc_o      = pc_q;
  assign busy_o    = active;
  assign illegal_o = illegal_q;

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (active && !done_o) |=> $stable(pc_q)); // R3
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!busy_o && pc_q == $past(pc_q) + $past(cfg_len_q))); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (active && start_i && !done_o) |=> (busy_o && $stable(cfg_vl_q) && $stable(cfg_cnt_q))); // R10
  AST_ILLEGAL_SET: assert property (@(posedge clk) disable iff (rst)
    (active && branch_i) |=> illegal_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!active && !start_i) |=> ($stable(pc_q) && !busy_o)); // R11
  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> (busy_o && pc_q == $past(base_pc_i))); // R2

endmodule

// File: rtl/vblk_seq.sv
`timescale 1ns/1ps
module vblk_seq #(
  parameter int PC_W  = 32,
  parameter int BLK_W = 5,
  parameter int VL_W  = 6,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PC_W-1:0]  base_pc_i,
  input  logic [BLK_W-1:0] instr_cnt_i,
  input  logic [PC_W-1:0]  block_len_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [SUB_W-1:0] subvl_i,
  input  logic             step_i,
  input  logic             branch_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [BLK_W-1:0] blk_idx_o,
  output logic [VL_W-1:0]  elem_idx_o,
  output logic [SUB_W-1:0] sub_idx_o,
  output logic             busy_o,
  output logic             illegal_o
);

  logic             clr;
  logic             sub_adv, elem_adv, blk_adv, done;
  logic             vl_zero;
  logic             sub_at_last, elem_at_last, blk_at_last;
  logic [SUB_W-1:0] sub_last;
  logic [VL_W-1:0]  elem_last;
  logic [BLK_W-1:0] blk_last;

  vblk_ctrl #(.PC_W(PC_W), .BLK_W(BLK_W), .VL_W(VL_W), .SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .base_pc_i(base_pc_i),
    .instr_cnt_i(instr_cnt_i), .block_len_i(block_len_i), .vl_i(vl_i),
    .subvl_i(subvl_i), .step_i(step_i), .branch_i(branch_i),
    .sub_at_last_i(sub_at_last), .elem_at_last_i(elem_at_last),
    .blk_at_last_i(blk_at_last), .clr_o(clr), .sub_adv_o(sub_adv),
    .elem_adv_o(elem_adv), .blk_adv_o(blk_adv), .done_o(done),
    .vl_zero_o(vl_zero), .sub_last_o(sub_last), .elem_last_o(elem_last),
    .blk_last_o(blk_last), .pc_o(pc_o), .busy_o(busy_o), .illegal_o(illegal_o)
  );

  vblk_wrap_cnt #(.W(SUB_W)) u_sub (
    .clk(clk), .rst(rst), .clr_i(clr), .adv_i(sub_adv), .last_i(sub_last),
    .idx_o(sub_idx_o), .at_last_o(sub_at_last)
  );

  vblk_wrap_cnt #(.W(VL_W)) u_elem (
    .clk(clk), .rst(rst), .clr_i(clr), .adv_i(elem_adv), .last_i(elem_last),
    .idx_o(elem_idx_o), .at_last_o(elem_at_last)
  );

  vblk_wrap_cnt #(.W(BLK_W)) u_blk (
    .clk(clk), .rst(rst), .clr_i(clr), .adv_i(blk_adv), .last_i(blk_last),
    .idx_o(blk_idx_o), .at_last_o(blk_at_last)
  );

  AST_BRANCH_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && branch_i) |=> ($stable(blk_idx_o) && $stable(elem_idx_o) && $stable(sub_idx_o) && $stable(pc_o))); // R7
  AST_INSTR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !vl_zero && !start_i && !(sub_at_last && elem_at_last)) |=> $stable(blk_idx_o)); // R6
  AST_VL0_SKIP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && vl_zero) |-> (elem_idx_o == '0 && sub_idx_o == '0)); // R9
  AST_EXIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done |=> (blk_idx_o == '0 && elem_idx_o == '0 && sub_idx_o == '0)); // R8

endmodule

// File: tb/test_vblk_seq.sv
`timescale 1ns/1ps
module test_vblk_seq;

  localparam int PC_W = 32, BLK_W = 5, VL_W = 6, SUB_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, step_i = 1'b0, branch_i = 1'b0;
  logic [PC_W-1:0]  base_pc_i = '0, block_len_i = '0;
  logic [BLK_W-1:0] instr_cnt_i = '0;
  logic [VL_W-1:0]  vl_i = '0;
  logic [SUB_W-1:0] subvl_i = '0;
  logic [PC_W-1:0]  pc_o;
  logic [BLK_W-1:0] blk_idx_o;
  logic [VL_W-1:0]  elem_idx_o;
  logic [SUB_W-1:0] sub_idx_o;
  logic busy_o, illegal_o;

  always #4 clk = ~clk; // 125 MHz

  vblk_seq #(.PC_W(PC_W), .BLK_W(BLK_W), .VL_W(VL_W), .SUB_W(SUB_W)) i_vblk_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .base_pc_i(base_pc_i),
    .instr_cnt_i(instr_cnt_i), .block_len_i(block_len_i), .vl_i(vl_i),
    .subvl_i(subvl_i), .step_i(step_i), .branch_i(branch_i), .pc_o(pc_o),
    .blk_idx_o(blk_idx_o), .elem_idx_o(elem_idx_o), .sub_idx_o(sub_idx_o),
    .busy_o(busy_o), .illegal_o(illegal_o)
  );

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;

  // bench model state
  longint e_pc = 0;
  int e_blk = 0, e_elem = 0, e_sub = 0, m_vl = 0, m_sub = 1, m_cnt = 1;
  longint m_len = 0;
  bit e_busy = 0;

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, longint'(pc_o), e_pc, "pc");
    chk(req, longint'(blk_idx_o), e_blk, "blk_idx");
    chk(req, longint'(elem_idx_o), e_elem, "elem_idx");
    chk(req, longint'(sub_idx_o), e_sub, "sub_idx");
    chk(req, longint'(busy_o), longint'(e_busy), "busy");
  endtask

  task automatic model_step();
    bit nxt;
    if (!e_busy) return;
    nxt = 0;
    if (m_vl == 0) nxt = 1;
    else if (e_sub + 1 < m_sub) e_sub++;
    else begin
      e_sub = 0;
      if (e_elem + 1 < m_vl) e_elem++;
      else begin e_elem = 0; nxt = 1; end
    end
    if (nxt) begin
      if (e_blk + 1 < m_cnt) e_blk++;
      else begin e_blk = 0; e_busy = 0; e_pc = (e_pc + m_len) & 64'hFFFF_FFFF; end
    end
  endtask

  task automatic do_start(input longint base, input int cnt, input longint len, input int vl, input int sub);
    base_pc_i = PC_W'(base); instr_cnt_i = BLK_W'(cnt); block_len_i = PC_W'(len);
    vl_i = VL_W'(vl); subvl_i = SUB_W'(sub); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!e_busy) begin
      e_busy = 1; e_pc = base; e_blk = 0; e_elem = 0; e_sub = 0;
      m_cnt = (cnt == 0) ? 1 : cnt; m_vl = vl; m_sub = (sub == 0) ? 1 : sub; m_len = len;
    end
  endtask

  task automatic do_step();
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    model_step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_all("R1");
    chk("R1", longint'(illegal_o), 0, "illegal");
  endtask

  task automatic t_full_walk();
    do_start(64'h1000, 2, 8, 3, 2);
    chk_all("R2");
    for (int i = 0; i < 12; i++) begin
      do_step();
      chk_all("R3 R4 R5 R6");
    end
    chk("R8", longint'(pc_o), 64'h1008, "exit pc");
    chk("R8", longint'(busy_o), 0, "busy after exit");
  endtask

  task automatic t_subvl_zero();
    do_start(64'h2000, 1, 4, 2, 0);
    do_step();
    chk("R4", longint'(elem_idx_o), 1, "subvl0 carries each step");
    chk_all("R4");
    do_step();
    chk_all("R4");
    chk("R8", longint'(pc_o), 64'h2004, "exit pc subvl0");
  endtask

  task automatic t_vl_zero();
    do_start(64'h3000, 3, 12, 0, 3);
    for (int i = 0; i < 3; i++) begin
      do_step();
      chk_all("R9");
    end
    chk("R9", longint'(busy_o), 0, "vl0 exit after count steps");
  endtask

  task automatic t_cnt_zero();
    do_start(64'h4000, 0, 4, 1, 1);
    chk_all("R2");
    do_step();
    chk_all("R8");
    chk("R8", longint'(pc_o), 64'h4004, "count0 single instruction");
  endtask

  task automatic t_branch();
    do_start(64'h5000, 2, 8, 2, 1);
    do_step();
    chk_all("R5");
    branch_i = 1'b1; step_i = 1'b1;
    @(negedge clk);
    branch_i = 1'b0; step_i = 1'b0;
    chk_all("R7");
    chk("R7", longint'(illegal_o), 1, "illegal after branch");
    @(negedge clk);
    chk("R7", longint'(illegal_o), 0, "illegal one cycle");
    for (int i = 0; i < 3; i++) do_step();
    chk_all("R7");
    branch_i = 1'b1;
    @(negedge clk);
    branch_i = 1'b0;
    chk("R7", longint'(illegal_o), 0, "branch while idle");
  endtask

  task automatic t_start_busy();
    do_start(64'h6000, 2, 16, 1, 2);
    do_step();
    do_start(64'h9999, 5, 4, 4, 3);
    chk_all("R10");
    for (int i = 0; i < 3; i++) do_step();
    chk_all("R10");
    chk("R10", longint'(pc_o), 64'h6010, "exit uses first config");
  endtask

  task automatic t_idle_step();
    for (int i = 0; i < 3; i++) do_step();
    chk_all("R11");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_full_walk();
    t_subvl_zero();
    t_vl_zero();
    t_cnt_zero();
    t_branch();
    t_start_busy();
    t_idle_step();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule